// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the architectural state update that happens when a small embedded processor core takes a general exception or a debug exception. The pipeline presents a request in one cycle, with a cause code, the faulting program counter and, optionally, a faulting virtual address. On the next clock edge the block has updated every save register and the processor status word (PS). It also raises a one-cycle pulse that carries the selected vector: kernel, user, double or debug.

A general exception that arrives while the exception-mode bit of PS is already set is a nested fault. Its PC goes to a dedicated double-exception PC register, and the double vector is selected. A debug request is honoured only when the current interrupt level is below the configured debug level. When taken, it saves PS and the PC into save registers for that level and raises the interrupt level to the debug level. A misaligned access is turned into an alignment exception only in configurations that trap unaligned accesses and lack hardware alignment support.

PS layout: bits [3:0] hold the interrupt level, bit 4 is EXCM (exception mode) and bit 5 is UM (user mode). All other bits are carried along unchanged. Vector codes are 0 kernel, 1 user, 2 double and 3 debug.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset PS equals the PS_RESET parameter (default 0x0010). All PC, cause and address save registers are zero, and vec_valid is 0.
- R2: A general exception taken with PS bit 4 (EXCM) clear writes the request PC into epc1. It selects vector 1 (user) when PS bit 5 (UM) is set and vector 0 (kernel) when UM is clear.
- R3: A general exception taken with EXCM already set selects vector 2 (double). It writes the PC into depc when HAS_DEPC is 1 and into epc1 otherwise. The register not written keeps its value.
- R4: Every taken general exception writes its cause into exc_cause_q and sets PS bit 4, leaving all other PS bits unchanged.
- R5: exc_vaddr_q is written with the request address only when the taken general exception carries an address. Otherwise it keeps its value.
- R6: A debug request is taken only when PS[3:0] is strictly less than DBG_LEVEL (default 6). Otherwise it has no effect, and a general request in the same cycle is taken as if the debug request were absent.
- R7: A taken debug exception writes the debug cause into dbg_cause_q and the PC into epc_dbg, and copies the PS value from before the entry into eps_dbg.
- R8: A taken debug exception sets PS[3:0] to DBG_LEVEL and sets PS bit 4. All other PS bits are unchanged, and the vector is 3.
- R9: A misaligned-access request raises a general exception with cause ALIGN_CAUSE (default 9) and its address only when OPT_UNALIGNED_EXC is 1 and OPT_HW_ALIGN is 0 (the defaults). An explicit general request in the same cycle takes precedence.
- R10: All updates for one exception commit on the clock edge that samples the request. vec_valid is high for exactly the following cycle per taken request, with vec_sel valid alongside it, and is low when no request is taken.
- R11: When debug and general requests are both present and the debug request is taken, the general request is dropped: epc1, depc, exc_cause_q and exc_vaddr_q are unchanged.
- R12: ps_load loads ps_load_val into PS in a cycle where no exception is taken. A taken exception in the same cycle overrides the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | General exception cause code |
| exc_has_vaddr | input | 1 | Request carries a faulting address |
| exc_vaddr | input | XLEN | Faulting virtual address |
| mis_req | input | 1 | Misaligned load/store detected |
| mis_vaddr | input | XLEN | Address of the misaligned access |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | CAUSE_W | Debug cause code |
| req_pc | input | XLEN | PC of the faulting instruction |
| ps_load | input | 1 | Load PS from ps_load_val |
| ps_load_val | input | PS_W | New PS value |
| ps | output | PS_W | Processor status word |
| epc1 | output | XLEN | First-level exception PC |
| depc | output | XLEN | Double-exception PC |
| exc_cause_q | output | CAUSE_W | Latched exception cause |
| exc_vaddr_q | output | XLEN | Latched faulting address |
| dbg_cause_q | output | CAUSE_W | Latched debug cause |
| epc_dbg | output | XLEN | PC saved for the debug level |
| eps_dbg | output | PS_W | PS saved for the debug level |
| vec_valid | output | 1 | One-cycle redirect pulse |
| vec_sel | output | 2 | Selected vector (0 kernel, 1 user, 2 double, 3 debug) |

## Verification
On every cycle, the assertions check the state that must accompany a redirect pulse. EXCM must be set after any entry, and a debug pulse must leave the debug level in PS and a copy of the old PS in eps_dbg. A double pulse must follow a cycle in which EXCM was already set, and a kernel pulse must leave the faulting PC in epc1. The assertions also check that the address register never moves without a pulse. Only the bench scenarios can show the decisions that depend on what was left out: a blocked debug request, a debug request winning over a general one, a misaligned access losing to an explicit fault, and a PS load overridden by an entry. Each is checked through the registers that the dropped request would have written.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // PS field positions
  localparam int PS_IL_LSB = 0;
  localparam int PS_IL_W   = 4;
  localparam int PS_EXCM   = 4;
  localparam int PS_UM     = 5;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;
endpackage

// File: rtl/exc_align_gate.sv
module exc_align_gate #(
  parameter int XLEN              = 32,
  parameter int CAUSE_W           = 6,
  parameter bit OPT_UNALIGNED_EXC = 1'b1,
  parameter bit OPT_HW_ALIGN      = 1'b0,
  parameter int ALIGN_CAUSE       = 9
) (
  input  logic               in_req,
  input  logic [CAUSE_W-1:0] in_cause,
  input  logic               in_has_va,
  input  logic [XLEN-1:0]    in_va,
  input  logic               mis_req,
  input  logic [XLEN-1:0]    mis_va,
  output logic               out_req,
  output logic [CAUSE_W-1:0] out_cause,
  output logic               out_has_va,
  output logic [XLEN-1:0]    out_va
);
  localparam bit TRAP_MISALIGN = OPT_UNALIGNED_EXC && !OPT_HW_ALIGN;
  localparam logic [CAUSE_W-1:0] ALIGN_CODE = CAUSE_W'(ALIGN_CAUSE);

  generate
    if (TRAP_MISALIGN) begin : g_trap
      always_comb begin
        if (in_req) begin
          out_req    = 1'b1;
          out_cause  = in_cause;
          out_has_va = in_has_va;
          out_va     = in_va;
        end else begin
          out_req    = mis_req;
          out_cause  = ALIGN_CODE;
          out_has_va = mis_req;
          out_va     = mis_va;
        end
      end
    end else begin : g_pass
      logic unused_mis;
      assign unused_mis = mis_req ^ (^mis_va);
      assign out_req    = in_req;
      assign out_cause  = in_cause;
      assign out_has_va = in_has_va;
      assign out_va     = in_va;
    end
  endgenerate
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int PS_W      = 16,
  parameter int DBG_LEVEL = 6
) (
  input  logic [PS_W-1:0] ps_cur,
  input  logic            dbg_req,
  input  logic            gen_req,
  output logic            take_dbg,
  output logic            take_gen,
  output vec_e            vsel
);
  localparam logic [PS_IL_W-1:0] DBG_IL = PS_IL_W'(DBG_LEVEL);

  logic [PS_IL_W-1:0] cur_il;
  logic               dbg_allowed;

  assign cur_il      = ps_cur[PS_IL_LSB +: PS_IL_W];
  assign dbg_allowed = cur_il < DBG_IL;

  always_comb begin
    take_dbg = dbg_req && dbg_allowed;
    take_gen = gen_req && !take_dbg;
    if (take_dbg)                vsel = VEC_DEBUG;
    else if (ps_cur[PS_EXCM])    vsel = VEC_DOUBLE;
    else if (ps_cur[PS_UM])      vsel = VEC_USER;
    else                         vsel = VEC_KERNEL;
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CAUSE_W   = 6,
  parameter int              PS_W      = 16,
  parameter int              DBG_LEVEL = 6,
  parameter bit              HAS_DEPC  = 1'b1,
  parameter logic [PS_W-1:0] PS_RESET  = 16'h0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_gen,
  input  logic               take_dbg,
  input  vec_e               vsel,
  input  logic [CAUSE_W-1:0] gen_cause,
  input  logic               gen_has_va,
  input  logic [XLEN-1:0]    gen_va,
  input  logic [CAUSE_W-1:0] dbg_cause,
  input  logic [XLEN-1:0]    pc,
  input  logic               ps_load,
  input  logic [PS_W-1:0]    ps_load_val,
  output logic [PS_W-1:0]    ps_q,
  output logic [XLEN-1:0]    epc1_q,
  output logic [XLEN-1:0]    depc_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    vaddr_q,
  output logic [CAUSE_W-1:0] dcause_q,
  output logic [XLEN-1:0]    epcd_q,
  output logic [PS_W-1:0]    epsd_q,
  output logic               valid_q,
  output vec_e               vsel_q
);
  localparam logic [PS_IL_W-1:0] DBG_IL = PS_IL_W'(DBG_LEVEL);

  logic [PS_W-1:0]    ps_d;
  logic [XLEN-1:0]    epc1_d, depc_d, vaddr_d, epcd_d;
  logic [CAUSE_W-1:0] cause_d, dcause_d;
  logic [PS_W-1:0]    epsd_d;
  logic               ps_en, epc1_en, depc_en, cause_en, vaddr_en, dbg_en;
  logic               nested;

  assign nested = ps_q[PS_EXCM];

  // enables
  always_comb begin
    dbg_en   = take_dbg;
    cause_en = take_gen;
    vaddr_en = take_gen && gen_has_va;
    depc_en  = take_gen && nested && HAS_DEPC;
    epc1_en  = take_gen && !(nested && HAS_DEPC);
    ps_en    = take_gen || take_dbg || ps_load;
  end

  // next-state values
  always_comb begin
    ps_d = ps_q;
    if (take_dbg) begin
      ps_d[PS_IL_LSB +: PS_IL_W] = DBG_IL;
      ps_d[PS_EXCM]              = 1'b1;
    end else if (take_gen) begin
      ps_d[PS_EXCM]              = 1'b1;
    end else if (ps_load) begin
      ps_d = ps_load_val;
    end
    epc1_d   = pc;
    depc_d   = pc;
    cause_d  = gen_cause;
    vaddr_d  = gen_va;
    dcause_d = dbg_cause;
    epcd_d   = pc;
    epsd_d   = ps_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q     <= PS_RESET;
      epc1_q   <= '0;
      depc_q   <= '0;
      cause_q  <= '0;
      vaddr_q  <= '0;
      dcause_q <= '0;
      epcd_q   <= '0;
      epsd_q   <= '0;
      valid_q  <= 1'b0;
      vsel_q   <= VEC_KERNEL;
    end else begin
      if (ps_en)    ps_q    <= ps_d;
      if (epc1_en)  epc1_q  <= epc1_d;
      if (depc_en)  depc_q  <= depc_d;
      if (cause_en) cause_q <= cause_d;
      if (vaddr_en) vaddr_q <= vaddr_d;
      if (dbg_en) begin
        dcause_q <= dcause_d;
        epcd_q   <= epcd_d;
        epsd_q   <= epsd_d;
      end
      valid_q <= take_gen || take_dbg;
      if (take_gen || take_dbg) vsel_q <= vsel;
    end
  end

  // R4
  entry_sets_excm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ps_q[PS_EXCM]);
  // R8
  dbg_level_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && vsel_q == VEC_DEBUG) |-> ps_q[PS_IL_LSB +: PS_IL_W] == DBG_IL);
  // R7
  dbg_ps_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_dbg) |=> (epsd_q == $past(ps_q)));
  // R3
  double_needs_excm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_gen |=> ((vsel_q == VEC_DOUBLE) == $past(ps_q[PS_EXCM])));
  // R2
  kernel_pc_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_gen && !ps_q[PS_EXCM]) |=> (epc1_q == $past(pc)));
  // R5
  vaddr_only_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vaddr_q) |-> valid_q);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN              = 32,
  parameter int              CAUSE_W           = 6,
  parameter int              PS_W              = 16,
  parameter int              DBG_LEVEL         = 6,
  parameter bit              HAS_DEPC          = 1'b1,
  parameter bit              OPT_UNALIGNED_EXC = 1'b1,
  parameter bit              OPT_HW_ALIGN      = 1'b0,
  parameter int              ALIGN_CAUSE       = 9,
  parameter logic [PS_W-1:0] PS_RESET          = 16'h0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_has_vaddr,
  input  logic [XLEN-1:0]    exc_vaddr,
  input  logic               mis_req,
  input  logic [XLEN-1:0]    mis_vaddr,
  input  logic               dbg_req,
  input  logic [CAUSE_W-1:0] dbg_cause,
  input  logic [XLEN-1:0]    req_pc,
  input  logic               ps_load,
  input  logic [PS_W-1:0]    ps_load_val,
  output logic [PS_W-1:0]    ps,
  output logic [XLEN-1:0]    epc1,
  output logic [XLEN-1:0]    depc,
  output logic [CAUSE_W-1:0] exc_cause_q,
  output logic [XLEN-1:0]    exc_vaddr_q,
  output logic [CAUSE_W-1:0] dbg_cause_q,
  output logic [XLEN-1:0]    epc_dbg,
  output logic [PS_W-1:0]    eps_dbg,
  output logic               vec_valid,
  output logic [1:0]         vec_sel
);
  logic               g_req, g_has_va;
  logic [CAUSE_W-1:0] g_cause;
  logic [XLEN-1:0]    g_va;
  logic               take_dbg, take_gen;
  vec_e               vsel, vsel_q;

  exc_align_gate #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W),
    .OPT_UNALIGNED_EXC(OPT_UNALIGNED_EXC), .OPT_HW_ALIGN(OPT_HW_ALIGN),
    .ALIGN_CAUSE(ALIGN_CAUSE)
  ) u_gate (
    .in_req(exc_req), .in_cause(exc_cause), .in_has_va(exc_has_vaddr),
    .in_va(exc_vaddr), .mis_req(mis_req), .mis_va(mis_vaddr),
    .out_req(g_req), .out_cause(g_cause), .out_has_va(g_has_va), .out_va(g_va)
  );

  exc_arbiter #(.PS_W(PS_W), .DBG_LEVEL(DBG_LEVEL)) u_arb (
    .ps_cur(ps), .dbg_req(dbg_req), .gen_req(g_req),
    .take_dbg(take_dbg), .take_gen(take_gen), .vsel(vsel)
  );

  exc_state_regs #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .PS_W(PS_W), .DBG_LEVEL(DBG_LEVEL),
    .HAS_DEPC(HAS_DEPC), .PS_RESET(PS_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .take_gen(take_gen), .take_dbg(take_dbg),
    .vsel(vsel), .gen_cause(g_cause), .gen_has_va(g_has_va), .gen_va(g_va),
    .dbg_cause(dbg_cause), .pc(req_pc), .ps_load(ps_load),
    .ps_load_val(ps_load_val), .ps_q(ps), .epc1_q(epc1), .depc_q(depc),
    .cause_q(exc_cause_q), .vaddr_q(exc_vaddr_q), .dcause_q(dbg_cause_q),
    .epcd_q(epc_dbg), .epsd_q(eps_dbg), .valid_q(vec_valid), .vsel_q(vsel_q)
  );

  assign vec_sel = vsel_q;

  // R10
  pulse_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req || mis_req || dbg_req) |=> !vec_valid);
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, exc_has_vaddr, mis_req, dbg_req, ps_load;
  logic [5:0]  exc_cause, dbg_cause;
  logic [31:0] exc_vaddr, mis_vaddr, req_pc;
  logic [15:0] ps_load_val;
  logic [15:0] ps, eps_dbg;
  logic [31:0] epc1, depc, exc_vaddr_q, epc_dbg;
  logic [5:0]  exc_cause_q, dbg_cause_q;
  logic        vec_valid;
  logic [1:0]  vec_sel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_has_vaddr(exc_has_vaddr), .exc_vaddr(exc_vaddr), .mis_req(mis_req),
    .mis_vaddr(mis_vaddr), .dbg_req(dbg_req), .dbg_cause(dbg_cause),
    .req_pc(req_pc), .ps_load(ps_load), .ps_load_val(ps_load_val), .ps(ps),
    .epc1(epc1), .depc(depc), .exc_cause_q(exc_cause_q),
    .exc_vaddr_q(exc_vaddr_q), .dbg_cause_q(dbg_cause_q), .epc_dbg(epc_dbg),
    .eps_dbg(eps_dbg), .vec_valid(vec_valid), .vec_sel(vec_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    exc_req = 0; exc_has_vaddr = 0; mis_req = 0; dbg_req = 0; ps_load = 0;
  endtask

  // one request cycle; on return the commit edge has passed and inputs are idle
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic load_ps(input logic [15:0] v);
    ps_load = 1; ps_load_val = v;
    step();
    chk("R12 idle load", {16'h0, ps}, {16'h0, v});
  endtask

  task automatic t_reset();
    chk("R1 ps", {16'h0, ps}, 32'h0010);
    chk("R1 epc1", epc1, 0);
    chk("R1 depc", depc, 0);
    chk("R1 vaddr", exc_vaddr_q, 0);
    chk("R1 valid", {31'h0, vec_valid}, 0);
  endtask

  task automatic t_kernel();
    load_ps(16'h0000);
    exc_req = 1; exc_cause = 6'd5; req_pc = 32'h1000_0040;
    exc_vaddr = 32'hDEAD_0000;
    step();
    chk("R2 epc1", epc1, 32'h1000_0040);
    chk("R2 kernel vec", {30'h0, vec_sel}, 0);
    chk("R10 pulse", {31'h0, vec_valid}, 1);
    chk("R4 cause", {26'h0, exc_cause_q}, 5);
    chk("R4 ps excm", {16'h0, ps}, 32'h0010);
    chk("R5 vaddr kept", exc_vaddr_q, 0);
    @(negedge clk);
    chk("R10 pulse ends", {31'h0, vec_valid}, 0);
  endtask

  task automatic t_double();
    exc_req = 1; exc_cause = 6'd7; req_pc = 32'h2000_0080;
    exc_has_vaddr = 1; exc_vaddr = 32'hCAFE_1234;
    step();
    chk("R3 depc", depc, 32'h2000_0080);
    chk("R3 epc1 kept", epc1, 32'h1000_0040);
    chk("R3 double vec", {30'h0, vec_sel}, 2);
    chk("R5 vaddr", exc_vaddr_q, 32'hCAFE_1234);
  endtask

  task automatic t_user();
    load_ps(16'h00A3);
    exc_req = 1; exc_cause = 6'd2; req_pc = 32'h3000_0010;
    step();
    chk("R2 user vec", {30'h0, vec_sel}, 1);
    chk("R2 epc1", epc1, 32'h3000_0010);
    chk("R4 ps bits kept", {16'h0, ps}, 32'h00B3);
  endtask

  task automatic t_debug();
    load_ps(16'h0025);
    dbg_req = 1; dbg_cause = 6'h11; req_pc = 32'h4000_0004;
    step();
    chk("R7 dbg cause", {26'h0, dbg_cause_q}, 32'h11);
    chk("R7 epc_dbg", epc_dbg, 32'h4000_0004);
    chk("R7 eps_dbg", {16'h0, eps_dbg}, 32'h0025);
    chk("R8 ps", {16'h0, ps}, 32'h0036);
    chk("R8 vec", {30'h0, vec_sel}, 3);
  endtask

  task automatic t_dbg_blocked();
    load_ps(16'h0006);
    dbg_req = 1; dbg_cause = 6'h22; req_pc = 32'h5000_0000;
    step();
    chk("R6 no pulse", {31'h0, vec_valid}, 0);
    chk("R6 dbg cause kept", {26'h0, dbg_cause_q}, 32'h11);
    chk("R6 ps kept", {16'h0, ps}, 32'h0006);
    load_ps(16'h0007);
    dbg_req = 1; exc_req = 1; exc_cause = 6'd3; req_pc = 32'h5000_0100;
    step();
    chk("R6 gen taken", {30'h0, vec_sel}, 0);
    chk("R6 epc1", epc1, 32'h5000_0100);
    chk("R6 epc_dbg kept", epc_dbg, 32'h4000_0004);
  endtask

  task automatic t_priority();
    load_ps(16'h0002);
    dbg_req = 1; dbg_cause = 6'h05; exc_req = 1; exc_cause = 6'd12;
    exc_has_vaddr = 1; exc_vaddr = 32'h1111_2222; req_pc = 32'h6000_0000;
    step();
    chk("R11 debug vec", {30'h0, vec_sel}, 3);
    chk("R11 cause kept", {26'h0, exc_cause_q}, 3);
    chk("R11 epc1 kept", epc1, 32'h5000_0100);
    chk("R11 vaddr kept", exc_vaddr_q, 32'hCAFE_1234);
    chk("R11 depc kept", depc, 32'h2000_0080);
  endtask

  task automatic t_align();
    load_ps(16'h0000);
    mis_req = 1; mis_vaddr = 32'h0000_0103; req_pc = 32'h7000_0000;
    step();
    chk("R9 align cause", {26'h0, exc_cause_q}, 9);
    chk("R9 align vaddr", exc_vaddr_q, 32'h0000_0103);
    chk("R9 pulse", {31'h0, vec_valid}, 1);
    load_ps(16'h0000);
    mis_req = 1; mis_vaddr = 32'h0000_0207; exc_req = 1; exc_cause = 6'd20;
    req_pc = 32'h7000_0010;
    step();
    chk("R9 explicit wins", {26'h0, exc_cause_q}, 20);
    chk("R9 vaddr kept", exc_vaddr_q, 32'h0000_0103);
  endtask

  task automatic t_load_vs_exc();
    load_ps(16'h0020);
    ps_load = 1; ps_load_val = 16'h00FF; exc_req = 1; exc_cause = 6'd1;
    req_pc = 32'h8000_0000;
    step();
    chk("R12 exc overrides load", {16'h0, ps}, 32'h0030);
    chk("R12 user vec", {30'h0, vec_sel}, 1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    exc_cause = 0; dbg_cause = 0; exc_vaddr = 0; mis_vaddr = 0;
    req_pc = 0; ps_load_val = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_kernel();
    t_double();
    t_user();
    t_debug();
    t_dbg_blocked();
    t_priority();
    t_align();
    t_load_vs_exc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule